// File: doc/BRIEF.md
# Keyed Access Unlock Gate

This block guards a protected information region behind a software key. Software writes three fixed 32-bit key words, one after another, into a single write-only key register. Only when all three arrive in the required order does the gate raise its `accessEnable` output. The rest of the chip uses that output to open reads and writes to the protected region.

Once the gate is open, any later write to the key register closes it again, whatever the value written. That closing write only closes the gate. It is not treated as the first word of a new attempt. The key register always reads back as zero, so the key cannot be recovered through the register port.

The register port is deliberately minimal: an address, a single-cycle write strobe, write data and read data. Writes to any other offset pass through the gate without touching the key sequence.

Top module: `keylock_gate`

## Requirements
- R1: While reset is asserted, and after it is released, `accessEnable` is 0 until a complete key sequence has been accepted.
- R2: Three writes to the key offset 0x40 carrying 0x3A7F5CA3, then 0xA1E34F20, then 0x9608B2C1 raise `accessEnable` at the clock edge that samples the third write.
- R3: After only the first one or two correct key words, `accessEnable` stays 0.
- R4: A key-offset write whose value does not match the expected next key word sends the sequence back to its start, so all three words must then be written again.
- R5: A mismatching key-offset write whose value equals the first key word (0x3A7F5CA3) counts as step one of a new attempt.
- R6: Writes to offsets other than 0x40 neither advance nor reset the sequence, and they do not close an open gate.
- R7: While `accessEnable` is 1, a write of any value to offset 0x40 drops `accessEnable` at the next clock edge.
- R8: The write that closes the gate does not count as step one, even if its value equals the first key word.
- R9: `regRdData` is always zero, whatever the address and whatever the lock state.
- R10: Cycles with `regWrEn` low have no effect on the sequence or on `accessEnable`, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W (8) | Byte offset of the register access |
| regWrEn | input | 1 | Single-cycle write strobe |
| regWrData | input | DATA_W (32) | Write data |
| regRdData | output | DATA_W (32) | Read data, always zero |
| accessEnable | output | 1 | High while the protected region is unlocked |

## Verification
Each write changes `accessEnable` at the clock edge that samples it, so that write's result is visible one edge later. The key register has no read-side state, so `regRdData` is valid in every cycle. The driver applies each write on a falling edge and then waits one rising edge. It then queues the value that a reference model built from the requirements predicts. The monitor pops that value at the next falling edge and compares it against `accessEnable` and `regRdData`. Every comparison therefore lands half a cycle after the register updates, well away from any clock edge.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

  // Events the datapath reports to the control for one cycle.
  typedef struct packed {
    logic keyWrite;    // strobed write at the key offset
    logic stepMatch;   // data equals the key word expected next
    logic firstMatch;  // data equals the first key word
  } keyEvt_t;

  // Lock state held by the control.
  typedef enum logic {
    GATE_CLOSED = 1'b0,
    GATE_OPEN   = 1'b1
  } gateState_t;

endpackage

// File: rtl/keylock_dp.sv
module keylock_dp
  import keylock_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_KEYS = 3,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h40,
  parameter logic [NUM_KEYS*DATA_W-1:0] KEY_SEQ = '0,
  localparam int STEP_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [STEP_W-1:0] step,
  output keyEvt_t           evt,
  output logic [DATA_W-1:0] regRdData
);

  logic [DATA_W-1:0] keyArr [NUM_KEYS];
  logic [NUM_KEYS-1:0] matchVec;

  // Unpack the key list and compare the write data with every key in parallel.
  for (genvar gi = 0; gi < NUM_KEYS; gi++) begin : g_key
    assign keyArr[gi]   = KEY_SEQ[gi*DATA_W +: DATA_W];
    assign matchVec[gi] = (regWrData == keyArr[gi]);
  end

  logic addrHit;
  logic stepSel;

  assign addrHit = (regAddr == KEY_ADDR);

  // Pick the compare result for the step the control is waiting on.
  always_comb begin
    stepSel = 1'b0;
    for (int k = 0; k < NUM_KEYS; k++) begin
      if (step == STEP_W'(k)) stepSel = matchVec[k];
    end
  end

  assign evt.keyWrite   = regWrEn && addrHit;
  assign evt.stepMatch  = stepSel;
  assign evt.firstMatch = matchVec[0];

  // The key register holds no readable state.
  assign regRdData = '0;

endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl
  import keylock_pkg::*;
#(
  parameter int NUM_KEYS = 3,
  localparam int STEP_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1,
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_KEYS - 1),
  localparam logic [STEP_W-1:0] AFTER_FIRST = (NUM_KEYS > 1) ? STEP_W'(1) : '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  keyEvt_t           evt,
  output logic [STEP_W-1:0] step,
  output logic              accessEnable
);

  gateState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= GATE_CLOSED;
      step  <= '0;
    end else if (evt.keyWrite) begin
      if (state == GATE_OPEN) begin
        // Any key write while open closes the gate and is consumed there.
        state <= GATE_CLOSED;
        step  <= '0;
      end else if (evt.stepMatch) begin
        if (step == LAST_STEP) begin
          state <= GATE_OPEN;
          step  <= '0;
        end else begin
          step <= step + STEP_W'(1);
        end
      end else if (evt.firstMatch) begin
        // A mismatching write that equals the first key starts a new attempt.
        step <= AFTER_FIRST;
      end else begin
        step <= '0;
      end
    end
  end

  assign accessEnable = (state == GATE_OPEN);

endmodule

// File: rtl/keylock_gate.sv
module keylock_gate
  import keylock_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_KEYS = 3,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h40,
  parameter logic [NUM_KEYS*DATA_W-1:0] KEY_SEQ =
    {32'h9608B2C1, 32'hA1E34F20, 32'h3A7F5CA3},
  localparam int STEP_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              accessEnable
);

  keyEvt_t           evt;
  logic [STEP_W-1:0] step;

  keylock_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_KEYS (NUM_KEYS),
    .KEY_ADDR (KEY_ADDR),
    .KEY_SEQ  (KEY_SEQ)
  ) u_dp (
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .step      (step),
    .evt       (evt),
    .regRdData (regRdData)
  );

  keylock_ctrl #(
    .NUM_KEYS (NUM_KEYS)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .evt          (evt),
    .step         (step),
    .accessEnable (accessEnable)
  );

endmodule

// File: rtl/keylock_chk.sv
module keylock_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_KEYS = 3,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h40,
  parameter logic [NUM_KEYS*DATA_W-1:0] KEY_SEQ = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              accessEnable
);

  localparam logic [DATA_W-1:0] LAST_KEY = KEY_SEQ[(NUM_KEYS-1)*DATA_W +: DATA_W];

  logic keyWr;
  assign keyWr = regWrEn && (regAddr == KEY_ADDR);

  // R1
  reset_locks_chk: assert property (@(posedge clk) !rstN |=> !accessEnable);

  // R2
  open_needs_last_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accessEnable) |-> $past(keyWr && regWrData == LAST_KEY));

  // R6
  other_offset_keeps_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accessEnable && !keyWr) |=> accessEnable);

  // R7
  relock_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accessEnable && keyWr) |=> !accessEnable);

  // R9
  read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdData == '0);

  // R10
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(accessEnable));

endmodule

bind keylock_gate keylock_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_KEYS (NUM_KEYS),
  .KEY_ADDR (KEY_ADDR),
  .KEY_SEQ  (KEY_SEQ)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regAddr      (regAddr),
  .regWrEn      (regWrEn),
  .regWrData    (regWrData),
  .regRdData    (regRdData),
  .accessEnable (accessEnable)
);

// File: tb/keylock_gate_tb.sv
module keylock_gate_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  KADDR = 8'h40;
  localparam logic [31:0] K0 = 32'h3A7F5CA3;
  localparam logic [31:0] K1 = 32'hA1E34F20;
  localparam logic [31:0] K2 = 32'h9608B2C1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        accessEnable;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keylock_gate u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .regAddr      (regAddr),
    .regWrEn      (regWrEn),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .accessEnable (accessEnable)
  );

  // Scoreboard queues: expected enable and the requirement tag.
  logic  expQ [$];
  string tagQ [$];

  // Reference model built from the requirements.
  int mStep = 0;
  bit mOpen = 1'b0;

  function automatic logic [31:0] keyAt(int i);
    return (i == 0) ? K0 : (i == 1) ? K1 : K2;
  endfunction

  function automatic void modelWrite(logic en, logic [7:0] a, logic [31:0] d);
    if (!(en && a == KADDR)) return;
    if (mOpen) begin
      mOpen = 1'b0; mStep = 0;
    end else if (d == keyAt(mStep)) begin
      if (mStep == 2) begin mOpen = 1'b1; mStep = 0; end
      else mStep = mStep + 1;
    end else if (d == K0) begin
      mStep = 1;
    end else begin
      mStep = 0;
    end
  endfunction

  task automatic drive(logic en, logic [7:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    regWrEn = en; regAddr = a; regWrData = d;
    @(posedge clk);
    modelWrite(en, a, d);
    expQ.push_back(mOpen);
    tagQ.push_back(tag);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic key(logic [31:0] d, string tag);
    drive(1'b1, KADDR, d, tag);
  endtask

  task automatic doReset(string tag);
    @(negedge clk);
    rstN = 1'b0;
    mOpen = 1'b0; mStep = 0;
    @(negedge clk);
    checks++;
    if (accessEnable !== 1'b0) begin
      failures++;
      $display("FAIL %s: accessEnable during reset actual=%0b expected=0", tag, accessEnable);
    end
    rstN = 1'b1;
  endtask

  // Monitor: compares one expected item half a cycle after its edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic  e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (accessEnable !== e) begin
        failures++;
        $display("FAIL %s: accessEnable actual=%0b expected=%0b", t, accessEnable, e);
      end
      checks++;
      if (regRdData !== 32'h0) begin
        failures++;
        $display("FAIL R9: regRdData actual=%h expected=00000000", regRdData);
      end
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finishRun();
  end

  initial begin
    doReset("R1");
    // R1 after release, before any write
    drive(1'b0, KADDR, K0, "R1");

    // R3 partial sequence, R2 full sequence
    key(K0, "R3"); key(K1, "R3"); key(K2, "R2");
    // R6 other offsets keep the gate open
    drive(1'b1, 8'h44, 32'h0, "R6");
    drive(1'b1, 8'h00, K0, "R6");
    // R10 strobe low at key offset
    drive(1'b0, KADDR, 32'h1234, "R10");
    // R7 any write closes
    key(32'h0, "R7");

    // R8 relock with first key is not a step
    key(K0, "R2"); key(K1, "R2"); key(K2, "R2");
    key(K0, "R8"); key(K1, "R8"); key(K2, "R8");
    key(K0, "R2"); key(K1, "R2"); key(K2, "R2");
    key(32'hDEADBEEF, "R7");

    // R4 wrong word partway
    key(K0, "R4"); key(32'h5555AAAA, "R4"); key(K1, "R4"); key(K2, "R4");
    key(K0, "R4"); key(K1, "R4"); key(K0 ^ 32'h1, "R4"); key(K2, "R4");
    key(K0, "R4"); key(K2, "R4"); key(K1, "R4");

    // R5 wrong word equal to first key restarts at step one
    key(K0, "R5"); key(K0, "R5"); key(K1, "R5"); key(K2, "R5");
    key(K1, "R7");
    key(K0, "R5"); key(K1, "R5"); key(K0, "R5"); key(K1, "R5"); key(K2, "R5");
    key(K2, "R7");

    // R6 interleaved other-offset writes
    key(K0, "R6"); drive(1'b1, 8'h30, K1, "R6");
    key(K1, "R6"); drive(1'b1, 8'h3C, 32'hFFFFFFFF, "R6");
    key(K2, "R6");
    key(K0, "R7");

    // R10 strobe-low key data does not advance
    key(K0, "R10"); drive(1'b0, KADDR, K1, "R10");
    drive(1'b0, KADDR, K2, "R10"); key(K1, "R10"); key(K2, "R10");

    // R1 reset while open
    doReset("R1");
    drive(1'b0, 8'h00, 32'h0, "R1");
    key(K1, "R1"); key(K2, "R1");

    @(negedge clk);
    @(negedge clk);
    finishRun();
  end

endmodule